// File: doc/BRIEF.md
# Kogge-Stone Parallel-Prefix Adder (8-bit)

This block adds two 8-bit unsigned operands with no clock and no state. The carries come from a parallel-prefix tree, not a ripple chain, so the deepest path grows with the logarithm of the width. Every bit first forms a generate and a propagate term. Three prefix stages, with spans of 1, 2 and 4, then merge those terms into group carries. A final row of sum cells combines each propagate bit with the carry that enters its position.

Operand A arrives on a dedicated 8-bit input. Operand B arrives on the input side of an 8-bit bidirectional pad group, and the block holds that group in input mode by driving its enables and its output values low. The carry-in is fixed at zero and no carry-out exists, so a total of 256 or more wraps modulo 256. The tree is built from four explicit cell types, and the datapath contains no behavioural addition.

Top module: `ksa_adder8`

## Requirements
- R1: For every operand pair, `sum_o` equals (`opa_i` + `opb_pad_i`) modulo 256.
- R2: Bit 0 of `sum_o` equals `opa_i[0]` XOR `opb_pad_i[0]`, because the carry-in is zero.
- R3: A carry created at bit 0 travels through a run of propagating bits. For example, 0x7F + 0x01 gives 0x80, and 0x55 + 0x2B gives 0x80.
- R4: Totals of 256 or more wrap with no carry-out. For example, 0xFF + 0x01 gives 0x00, 0xFF + 0xFF gives 0xFE, and 0x80 + 0x80 gives 0x00.
- R5: `opb_pad_oe_o` and `opb_pad_do_o` are 0x00 at all times, so the B pads act only as inputs.
- R6: The output depends only on the present operands. The same pair gives the same sum whatever pairs came before it.
- R7: The carry into bit 7 equals the carry out of the low seven bits of the operands. This carry is observed as `sum_o[7]` XOR `opa_i[7]` XOR `opb_pad_i[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 8 | Operand A |
| opb_pad_i | input | 8 | Operand B, taken from the input side of the bidirectional pads |
| opb_pad_oe_o | output | 8 | Output enables of the B pads, always 0 |
| opb_pad_do_o | output | 8 | Output values of the B pads, always 0 |
| sum_o | output | 8 | Sum modulo 256 |

## Verification
The bench targets carries that must cross the whole prefix tree, such as 0x7F + 0x01 and 0xFF + 0x01. A stage with a wrong span or a missing combine cell would leave the upper bits unchanged on these pairs. Pairs that total 256 or more check that the result wraps; a design that leaked a carry-in or mishandled bit 0 would give results that are off by one. A full sweep of all 65,536 pairs follows, so a fault in any single cell shows up as a mismatch. Repeating a pair after unrelated pairs catches any state held from earlier inputs.

// File: rtl/ksa_pkg.sv
package ksa_pkg;

  typedef enum logic [1:0] {
    CELL_PASS  = 2'd0,
    CELL_CARRY = 2'd1,
    CELL_FULL  = 2'd2
  } cell_kind_e;

  // Choose the prefix cell for bit position pos in a stage with the given span.
  // A position whose span points below bit 0 passes its terms through unchanged.
  // A position whose lower partner is already resolved down to bit 0 needs only a
  // group generate. Every other position merges both generate and propagate.
  function automatic cell_kind_e pick_cell(input int pos, input int span);
    if (pos < span)          return CELL_PASS;
    else if (pos < 2 * span) return CELL_CARRY;
    else                     return CELL_FULL;
  endfunction

endpackage

// File: rtl/ksa_gp_cell.sv
module ksa_gp_cell (
  input  logic a_i,
  input  logic b_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;
endmodule

// File: rtl/ksa_combine_cell.sv
module ksa_combine_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/ksa_carry_cell.sv
module ksa_carry_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  output logic g_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
endmodule

// File: rtl/ksa_sum_cell.sv
module ksa_sum_cell (
  input  logic p_i,
  input  logic c_i,
  output logic s_o
);
  assign s_o = p_i ^ c_i;
endmodule

// File: rtl/ksa_adder8.sv
module ksa_adder8 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_pad_i,
  output logic [WIDTH-1:0] opb_pad_oe_o,
  output logic [WIDTH-1:0] opb_pad_do_o,
  output logic [WIDTH-1:0] sum_o
);
  import ksa_pkg::*;

  localparam int STAGES = $clog2(WIDTH);

  // Generate and propagate terms at the input of each prefix stage.
  wire [STAGES:0][WIDTH-1:0] g_st;
  wire [STAGES:0][WIDTH-1:0] p_st;
  wire [WIDTH-1:0]           carry_in;

  // The B pads stay in input mode.
  assign opb_pad_oe_o = '0;
  assign opb_pad_do_o = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    ksa_gp_cell u_gp (
      .a_i (opa_i[i]),
      .b_i (opb_pad_i[i]),
      .g_o (g_st[0][i]),
      .p_o (p_st[0][i])
    );
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int SPAN = 1 << s;
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      if (pick_cell(i, SPAN) == CELL_PASS) begin : g_pass
        assign g_st[s+1][i] = g_st[s][i];
        assign p_st[s+1][i] = p_st[s][i];
      end else if (pick_cell(i, SPAN) == CELL_CARRY) begin : g_carry
        ksa_carry_cell u_carry (
          .g_hi_i (g_st[s][i]),
          .p_hi_i (p_st[s][i]),
          .g_lo_i (g_st[s][i-SPAN]),
          .g_o    (g_st[s+1][i])
        );
        assign p_st[s+1][i] = 1'b0;
      end else begin : g_full
        ksa_combine_cell u_comb (
          .g_hi_i (g_st[s][i]),
          .p_hi_i (p_st[s][i]),
          .g_lo_i (g_st[s][i-SPAN]),
          .p_lo_i (p_st[s][i-SPAN]),
          .g_o    (g_st[s+1][i]),
          .p_o    (p_st[s+1][i])
        );
      end
    end
  end

  // The carry into bit 0 is tied low; bit i takes the resolved generate of bit i-1.
  assign carry_in = {g_st[STAGES][WIDTH-2:0], 1'b0};

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    ksa_sum_cell u_sum (
      .p_i (p_st[0][i]),
      .c_i (carry_in[i]),
      .s_o (sum_o[i])
    );
  end

  // Final group propagates and the top carry are not needed.
  wire unused_prefix_bits;
  assign unused_prefix_bits = ^{p_st, g_st[STAGES][WIDTH-1]};

endmodule

// File: rtl/ksa_adder8_chk.sv
module ksa_adder8_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_pad_i,
  input logic [WIDTH-1:0] sum_o
);
  logic [WIDTH:0]   wide_total;
  logic [WIDTH-1:0] low_total;

  assign wide_total = {1'b0, opa_i} + {1'b0, opb_pad_i};
  assign low_total  = {1'b0, opa_i[WIDTH-2:0]} + {1'b0, opb_pad_i[WIDTH-2:0]};

  always_comb begin
    // R1
    sum_mod_chk: assert (sum_o == wide_total[WIDTH-1:0])
      else $error("sum mismatch a=%h b=%h sum=%h", opa_i, opb_pad_i, sum_o);
    // R2
    lsb_no_cin_chk: assert (sum_o[0] == (opa_i[0] ^ opb_pad_i[0]))
      else $error("bit0 mismatch a=%h b=%h", opa_i, opb_pad_i);
    // R4
    wrap_no_cout_chk: assert (!wide_total[WIDTH] || (sum_o == wide_total[WIDTH-1:0]))
      else $error("wrap mismatch a=%h b=%h sum=%h", opa_i, opb_pad_i, sum_o);
    // R7
    top_carry_chk: assert ((sum_o[WIDTH-1] ^ opa_i[WIDTH-1] ^ opb_pad_i[WIDTH-1]) == low_total[WIDTH-1])
      else $error("top carry mismatch a=%h b=%h", opa_i, opb_pad_i);
  end
endmodule

bind ksa_adder8 ksa_adder8_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i     (opa_i),
  .opb_pad_i (opb_pad_i),
  .sum_o     (sum_o)
);

// File: tb/ksa_adder8_bench.sv
`timescale 1ns/1ps
module ksa_adder8_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] opa;
  logic [7:0] opb;
  logic [7:0] oe;
  logic [7:0] dout;
  logic [7:0] sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ksa_adder8 u_ksa_adder8 (
    .opa_i        (opa),
    .opb_pad_i    (opb),
    .opb_pad_oe_o (oe),
    .opb_pad_do_o (dout),
    .sum_o        (sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] ref_sum(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0];
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    opa = a;
    opb = b;
    #1;
  endtask

  task automatic try_pair(input string req, input logic [7:0] a, input logic [7:0] b);
    apply(a, b);
    check8(req, sum, ref_sum(a, b));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] ra, rb;
    logic [7:0] first;
    opa   = 8'h00;
    opb   = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero operands, pads held as inputs (R5).
    apply(8'h00, 8'h00);
    check8("R1 reset", sum, 8'h00);
    check8("R5 oe", oe, 8'h00);
    check8("R5 dout", dout, 8'h00);

    // R2: bit 0 has no carry-in.
    apply(8'h01, 8'h00); check8("R2", {7'd0, sum[0]}, 8'h01);
    apply(8'h01, 8'h01); check8("R2", {7'd0, sum[0]}, 8'h00);

    // R3: carries crossing every stage.
    apply(8'h7F, 8'h01); check8("R3", sum, 8'h80);
    apply(8'h55, 8'h2B); check8("R3", sum, 8'h80);
    apply(8'h0F, 8'h01); check8("R3", sum, 8'h10);

    // R4: wrap without carry-out.
    apply(8'hFF, 8'h01); check8("R4", sum, 8'h00);
    apply(8'hFF, 8'hFF); check8("R4", sum, 8'hFE);
    apply(8'h80, 8'h80); check8("R4", sum, 8'h00);

    // R7: carry into bit 7 from the low seven bits.
    apply(8'h40, 8'h40); check8("R7", {7'd0, sum[7] ^ opa[7] ^ opb[7]}, 8'h01);
    apply(8'h3F, 8'h40); check8("R7", {7'd0, sum[7] ^ opa[7] ^ opb[7]}, 8'h00);

    // R6: same pair after unrelated history.
    apply(8'hA5, 8'h3C); first = sum;
    try_pair("R6 history", 8'hFF, 8'hFF);
    try_pair("R6 history", 8'h00, 8'h01);
    apply(8'hA5, 8'h3C); check8("R6", sum, first);

    // Random pairs with a fixed seed (R1).
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 2000; k++) begin
      ra = 8'($urandom());
      rb = 8'($urandom());
      try_pair("R1 random", ra, rb);
    end

    // Exhaustive sweep (R1), pads checked along the way (R5).
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        try_pair("R1 sweep", 8'(a), 8'(b));
      end
      check8("R5 sweep oe", oe, 8'h00);
      check8("R5 sweep dout", dout, 8'h00);
    end

    finish_run();
  end
endmodule